// File: doc/BRIEF.md
# Dual-Clock FIFO with Partial Reset and Retransmit

This block is a one-way FIFO between two unrelated clock domains. Words enter on the write clock and leave on the read clock. Each pointer crosses to the other domain in Gray code through a two-flop synchronizer, so every status flag is registered in the domain that acts on it. The write-side flags are full (or input-ready) and almost-full. The read-side flags are empty (or output-ready) and almost-empty.

A master reset clears both pointers. While it is held, the block also captures its configuration: the read mode and the two flag thresholds. In standard mode a stored word stays in the array until a read asks for it. In fall-through mode the head word is moved on its own into an output stage, and a read then pops it. A partial reset flushes the pointers but keeps the captured configuration. A retransmit rewinds only the read pointer, so the stored data can be replayed. Retransmit uses the partial-reset strobe while the retransmit-mode input is high. It is meant for streams of fewer than DEPTH words written since the last flush.

Top module: `dcfifo_top`

## Requirements
- R1: While master reset is held and just after it is released, `rd_data` is zero and both pointers are at the first location. In standard mode `full_ir`=0, `empty_or`=1, `almost_empty`=1 and `almost_full`=0. In fall-through mode `full_ir`=1 and `empty_or`=0.
- R2: In standard mode words come out in write order. Each read with `rd_en` high while data is held loads the next word into `rd_data` at that read clock edge, and `rd_data` does not change on a cycle without a read.
- R3: In fall-through mode the oldest word appears on `rd_data` with `empty_or`=1 without any read. It holds until a cycle with `rd_en` high pops it, and the next word then appears at that same edge. The output stage adds one word, so the capacity is DEPTH+1.
- R4: In standard mode `full_ir` is high when the array holds DEPTH words and `empty_or` is high when it holds none. In fall-through mode `full_ir` is high while the array has a free slot and `empty_or` is high while a valid word is on `rd_data`.
- R5: A write while the array is full is dropped, and the write pointer does not move.
- R6: A read while the array is empty is dropped. The read pointer and `rd_data` stay as they were, and the next word written is the next word read.
- R7: `almost_empty` is high when the number of words in the array is at or below the captured `ae_level`. In fall-through mode the word in the output stage is not counted.
- R8: `almost_full` is high when the number of free array slots is at or below the captured `af_level`.
- R9: Partial reset (`prst_n` low while `rt_mode` is low) returns both pointers to the first location. Words stored before it are never read.
- R10: Retransmit (`prst_n` low while `rt_mode` is high) returns only the read pointer to the first location. Reads then replay from the first word written, and later writes are appended after the words already stored.
- R11: Mode and thresholds are taken from `fwft_sel`, `ae_level` and `af_level` only while master reset is held. Changes at other times, including during a partial reset, have no effect.
- R12: `prst_n` acts as a partial reset only while `rt_mode` is low. While `rt_mode` is high it never clears the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, or retransmit strobe when `rt_mode` is high; active low |
| rt_mode | input | 1 | Selects retransmit meaning of `prst_n` |
| fwft_sel | input | 1 | Read mode captured at master reset: 0 standard, 1 fall-through |
| ae_level | input | AW+1 | Almost-empty threshold captured at master reset |
| af_level | input | AW+1 | Almost-full threshold (free slots) captured at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request (pop in fall-through mode) |
| rd_data | output | DW | Read data |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_full | output | 1 | Almost-full flag, write domain |
| almost_empty | output | 1 | Almost-empty flag, read domain |

## Verification
The assertions check four things on every cycle: pointers do not move on a write while full or a read while empty, standard-mode data holds without a read, a fall-through word stays valid and stable until it is popped, and the array reads almost-empty whenever it reads empty. The bench scenarios cover the rest. These are threshold arithmetic at every fill level, write-order data, and keeping the configuration across a partial reset whose inputs have changed. They also cover replay after a retransmit and the extra word of capacity in fall-through mode.

// File: rtl/dcfifo_pkg.sv
// Shared definitions for the dual-clock FIFO.
package dcfifo_pkg;
    // Read behaviour captured at master reset.
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dcfifo_sync2.sv
// Two-flop synchronizer for a W-bit bus.
// Assumes a multi-bit bus is Gray coded or changes slowly relative to clk.
// Synchronous active-low reset loads RST_VAL.
module dcfifo_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the asynchronous input through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_wr.sv
// Write-side control: write pointer, full and almost-full flags, and
// write-domain configuration capture.
// Assumes rptr_gray_s is already synchronized into wclk.
module dcfifo_wr #(
    parameter int AW = 4
) (
    input  logic        wclk,
    input  logic        mrst_n_s,
    input  logic        ptr_clr,
    input  logic        fwft_in,
    input  logic [AW:0] af_in,
    input  logic        wr_en,
    input  logic [AW:0] rptr_gray_s,
    output logic [AW:0] wgray,
    output logic [AW-1:0] waddr,
    output logic        wr_fire,
    output logic        full_ir,
    output logic        almost_full
);
    import dcfifo_pkg::*;
    localparam int          PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

    logic          run;
    logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx;
    logic          full_q;
    rd_mode_e      mode_q;
    logic [PW-1:0] af_q;

    assign run     = mrst_n_s && !ptr_clr;
    assign wr_fire = run && wr_en && !full_q;
    assign wbin_nx = wbin + PW'(wr_fire);
    assign waddr   = wbin[AW-1:0];

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        rbin_s[PW-1] = rptr_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rptr_gray_s[i];
    end

    assign used_nx = wbin_nx - rbin_s;

    // Capture mode and threshold while master reset is held.
    always_ff @(posedge wclk) begin
        if (!mrst_n_s) begin
            mode_q <= rd_mode_e'(fwft_in);
            af_q   <= af_in;
        end
    end

    // Advance the write pointer and register flags from next-state values.
    always_ff @(posedge wclk) begin
        if (!run) begin
            wbin        <= '0;
            wgray       <= '0;
            full_q      <= 1'b0;
            almost_full <= 1'b0;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= wbin_nx ^ (wbin_nx >> 1);
            full_q      <= (used_nx == DEPTH_V);
            almost_full <= ((DEPTH_V - used_nx) <= af_q);
        end
    end

    assign full_ir = (mode_q == RD_FALLTHRU) ? !full_q : full_q;
endmodule

// File: rtl/dcfifo_rd.sv
// Read-side control: read pointer, output stage, empty and almost-empty
// flags, and read-domain configuration capture.
// Assumes wptr_gray_s is already synchronized into rclk and that mem_q is
// the array word at raddr.
module dcfifo_rd #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          rclk,
    input  logic          mrst_n_s,
    input  logic          ptr_clr,
    input  logic          fwft_in,
    input  logic [AW:0]   ae_in,
    input  logic          rd_en,
    input  logic [AW:0]   wptr_gray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data,
    output logic          empty_or,
    output logic          almost_empty
);
    import dcfifo_pkg::*;
    localparam int PW = AW + 1;

    logic          run, fetch, ovalid, empty_q;
    logic [PW-1:0] rbin, rbin_nx, wbin_s, used_nx;
    rd_mode_e      mode_q;
    logic [PW-1:0] ae_q;

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        wbin_s[PW-1] = wptr_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wptr_gray_s[i];
    end

    assign run     = mrst_n_s && !ptr_clr;
    assign fetch   = run && !empty_q &&
                     ((mode_q == RD_FALLTHRU) ? (!ovalid || rd_en) : rd_en);
    assign rbin_nx = rbin + PW'(fetch);
    assign used_nx = wbin_s - rbin_nx;
    assign raddr   = rbin[AW-1:0];

    // Capture mode and threshold while master reset is held.
    always_ff @(posedge rclk) begin
        if (!mrst_n_s) begin
            mode_q <= rd_mode_e'(fwft_in);
            ae_q   <= ae_in;
        end
    end

    // Advance the read pointer and register flags from next-state values.
    always_ff @(posedge rclk) begin
        if (!run) begin
            rbin         <= '0;
            rgray        <= '0;
            empty_q      <= 1'b1;
            almost_empty <= 1'b1;
        end else begin
            rbin         <= rbin_nx;
            rgray        <= rbin_nx ^ (rbin_nx >> 1);
            empty_q      <= (used_nx == '0);
            almost_empty <= (used_nx <= ae_q);
        end
    end

    // Track whether the output stage holds a valid word.
    always_ff @(posedge rclk) begin
        if (!run)        ovalid <= 1'b0;
        else if (fetch)  ovalid <= 1'b1;
        else if (rd_en)  ovalid <= 1'b0;
    end

    // Load the output register on each fetch.
    always_ff @(posedge rclk) begin
        if (!mrst_n_s)   rd_data <= '0;
        else if (fetch)  rd_data <= mem_q;
    end

    assign empty_or = (mode_q == RD_FALLTHRU) ? ovalid : empty_q;
endmodule

// File: rtl/dcfifo_top.sv
// Dual-clock FIFO top: storage array, control synchronizers, pointer
// crossings and the two side controllers.
// Assumes DEPTH = 2**AW and that resets are held for several cycles of the
// slower clock.
module dcfifo_top #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          rt_mode,
    input  logic          fwft_sel,
    input  logic [AW:0]   ae_level,
    input  logic [AW:0]   af_level,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full_ir,
    output logic          empty_or,
    output logic          almost_full,
    output logic          almost_empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [2:0]    ctl_w, ctl_r;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wr_fire;
    logic [DW-1:0] mem [DEPTH];

    // Bring the reset and retransmit controls into each domain.
    dcfifo_sync2 #(.W(3), .RST_VAL(3'b110)) u_ctl_w (
        .clk(wclk), .rst_n(1'b1), .d({mrst_n, prst_n, rt_mode}), .q(ctl_w));
    dcfifo_sync2 #(.W(3), .RST_VAL(3'b110)) u_ctl_r (
        .clk(rclk), .rst_n(1'b1), .d({mrst_n, prst_n, rt_mode}), .q(ctl_r));

    // Pointer crossings in Gray code.
    dcfifo_sync2 #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(ctl_w[2]), .d(rgray), .q(rgray_s));
    dcfifo_sync2 #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(ctl_r[2]), .d(wgray), .q(wgray_s));

    dcfifo_wr #(.AW(AW)) u_wr (
        .wclk(wclk), .mrst_n_s(ctl_w[2]), .ptr_clr(!ctl_w[1] && !ctl_w[0]),
        .fwft_in(fwft_sel), .af_in(af_level), .wr_en(wr_en),
        .rptr_gray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
        .full_ir(full_ir), .almost_full(almost_full));

    dcfifo_rd #(.AW(AW), .DW(DW)) u_rd (
        .rclk(rclk), .mrst_n_s(ctl_r[2]), .ptr_clr(!ctl_r[1]),
        .fwft_in(fwft_sel), .ae_in(ae_level), .rd_en(rd_en),
        .wptr_gray_s(wgray_s), .mem_q(mem[raddr]), .rgray(rgray), .raddr(raddr),
        .rd_data(rd_data), .empty_or(empty_or), .almost_empty(almost_empty));

    // Storage array written in the write domain.
    always_ff @(posedge wclk) begin
        if (wr_fire) mem[waddr] <= wr_data;
    end
endmodule

// File: rtl/dcfifo_chk.sv
// Property checker for dcfifo_top, attached with bind.
module dcfifo_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          w_run,
    input logic          r_run,
    input logic          wr_en,
    input logic          rd_en,
    input logic          mem_full,
    input logic          mem_empty,
    input logic          fwft_r,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rbin,
    input logic [DW-1:0] rd_data,
    input logic          empty_or,
    input logic          almost_empty
);
    // R5
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!w_run)
        (mem_full && wr_en) |=> $stable(wbin));

    // R6
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!r_run)
        mem_empty |=> $stable(rbin));

    // R2
    std_hold_chk: assert property (@(posedge rclk) disable iff (!r_run)
        (!fwft_r && !rd_en) |=> $stable(rd_data));

    // R3
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (!r_run)
        (fwft_r && empty_or && !rd_en) |=> (empty_or && $stable(rd_data)));

    // R7
    empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (!r_run)
        mem_empty |-> almost_empty);
endmodule

bind dcfifo_top dcfifo_chk #(.AW(AW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk),
    .w_run(u_wr.run), .r_run(u_rd.run),
    .wr_en(wr_en), .rd_en(rd_en),
    .mem_full(u_wr.full_q), .mem_empty(u_rd.empty_q),
    .fwft_r(u_rd.mode_q == dcfifo_pkg::RD_FALLTHRU),
    .wbin(u_wr.wbin), .rbin(u_rd.rbin),
    .rd_data(rd_data), .empty_or(empty_or), .almost_empty(almost_empty));

// File: tb/dcfifo_top_tb.sv
// Sweep bench for dcfifo_top with an 8-deep, 8-bit configuration.
module dcfifo_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_HALF  = 7;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic wclk = 0, rclk = 0;
    logic mrst_n = 0, prst_n = 1, rt_mode = 0, fwft_sel = 0;
    logic [AW:0] ae_level = 2, af_level = 3;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = 0;
    logic [DW-1:0] rd_data;
    logic full_ir, empty_or, almost_full, almost_empty;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_HALF) rclk = ~rclk;

    dcfifo_top #(.AW(AW), .DW(DW)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .rt_mode(rt_mode), .fwft_sel(fwft_sel), .ae_level(ae_level),
        .af_level(af_level), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .full_ir(full_ir), .empty_or(empty_or),
        .almost_full(almost_full), .almost_empty(almost_empty));

    function automatic logic [DW-1:0] pat(input int n, input int seed);
        return DW'(n * 37 + seed);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic mreset(input logic mode, input int ae, input int af);
        @(negedge wclk);
        mrst_n = 0; prst_n = 1; rt_mode = 0;
        fwft_sel = mode; ae_level = (AW+1)'(ae); af_level = (AW+1)'(af);
        repeat (6) @(negedge rclk);
        @(negedge wclk);
        mrst_n = 1;
        settle();
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge wclk); wr_en = 1; wr_data = v;
        @(negedge wclk); wr_en = 0;
    endtask

    task automatic pop();
        @(negedge rclk); rd_en = 1;
        @(negedge rclk); rd_en = 0;
    endtask

    task automatic strobe(input logic rtm);
        @(negedge wclk); rt_mode = rtm; prst_n = 0;
        repeat (6) @(negedge rclk);
        @(negedge wclk); prst_n = 1;
        settle();
        rt_mode = 0;
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state, standard mode
        mreset(0, 2, 3);
        chk("R1 full", full_ir, 0);
        chk("R1 empty", empty_or, 1);
        chk("R1 ae", almost_empty, 1);
        chk("R1 af", almost_full, 0);
        chk("R1 data", rd_data, 0);

        // R4 R7 R8 R2 R6: sweep fill level in standard mode
        for (int n = 0; n <= DEPTH; n++) begin
            mreset(0, 2, 3);
            for (int k = 0; k < n; k++) push(pat(k, n));
            settle();
            chk("R4 full", full_ir, (n == DEPTH) ? 1 : 0);
            chk("R4 empty", empty_or, (n == 0) ? 1 : 0);
            chk("R7 almost_empty", almost_empty, (n <= 2) ? 1 : 0);
            chk("R8 almost_full", almost_full, ((DEPTH - n) <= 3) ? 1 : 0);
            chk("R2 no read yet", rd_data, 0);
            for (int k = 0; k < n; k++) begin
                pop();
                chk("R2 order", rd_data, pat(k, n));
            end
            settle();
            chk("R4 empty after drain", empty_or, 1);
            pop();
            chk("R6 data kept", rd_data, (n == 0) ? 0 : pat(n - 1, n));
            push(8'hA5);
            settle();
            pop();
            chk("R6 next read", rd_data, 8'hA5);
        end

        // R5 overflow
        mreset(0, 2, 3);
        for (int k = 0; k < DEPTH + 2; k++) push(pat(k, 91));
        settle();
        chk("R5 full", full_ir, 1);
        for (int k = 0; k < DEPTH; k++) begin
            pop();
            chk("R5 order", rd_data, pat(k, 91));
        end
        settle();
        chk("R5 dropped words", empty_or, 1);

        // R9 R11 partial reset keeps captured settings
        mreset(0, 2, 3);
        for (int k = 0; k < 4; k++) push(pat(k, 5));
        ae_level = 6; af_level = 0; fwft_sel = 1;
        strobe(0);
        chk("R9 flushed empty", empty_or, 1);
        chk("R11 mode kept full", full_ir, 0);
        for (int k = 0; k < 3; k++) push(pat(k, 200));
        settle();
        chk("R11 ae threshold kept", almost_empty, 0);
        for (int k = 3; k < 6; k++) push(pat(k, 200));
        settle();
        chk("R11 af threshold kept", almost_full, 1);
        for (int k = 0; k < 6; k++) begin
            pop();
            chk("R9 old words gone", rd_data, pat(k, 200));
        end

        // R10 R12 retransmit
        mreset(0, 2, 3);
        for (int k = 0; k < 5; k++) push(pat(k, 17));
        for (int k = 0; k < 3; k++) begin
            pop();
            chk("R10 first pass", rd_data, pat(k, 17));
        end
        strobe(1);
        chk("R12 not flushed", empty_or, 0);
        push(pat(5, 17));
        settle();
        for (int k = 0; k < 6; k++) begin
            pop();
            chk("R10 replay", rd_data, pat(k, 17));
        end

        // R1 R3 R4 fall-through mode
        mreset(1, 2, 3);
        chk("R1 fwft ir", full_ir, 1);
        chk("R1 fwft or", empty_or, 0);
        push(pat(0, 60));
        settle();
        chk("R3 or", empty_or, 1);
        chk("R3 shown", rd_data, pat(0, 60));
        push(pat(1, 60)); push(pat(2, 60));
        settle();
        chk("R3 held", rd_data, pat(0, 60));
        for (int k = 1; k < 3; k++) begin
            pop();
            chk("R3 next", rd_data, pat(k, 60));
        end
        pop();
        settle();
        chk("R4 fwft or low", empty_or, 0);
        for (int k = 0; k < DEPTH; k++) push(pat(k, 70));
        settle();
        chk("R4 ir with slot", full_ir, 1);
        push(pat(DEPTH, 70));
        settle();
        chk("R4 ir low", full_ir, 0);
        for (int k = 0; k <= DEPTH; k++) begin
            chk("R3 order", rd_data, pat(k, 70));
            pop();
        end
        settle();
        chk("R4 or after drain", empty_or, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule